// File: doc/BRIEF.md
# GPIO Transition Interrupt Controller

This block watches a bank of general-purpose input pins that have already been brought into the clock domain. Any change of level on a pin, rising or falling, sets that pin's sticky status flag. A per-pin enable register decides which flags can raise the interrupt output. Software reads the status register to learn which pins moved. The read returns the flags and clears them in the same access. An edge that arrives in the same cycle as the read is kept for the next read.

A small configuration register chooses one of two interrupt styles:

- **Level style:** the interrupt is active while any enabled flag is pending.
- **Pulse style:** the interrupt is a train of fixed-width pulses separated by a fixed gap. The train continues until every enabled flag has been read.

The same register selects the active polarity of the interrupt pin. The pad is open-drain: it pulls low when `intPin` is 0 and releases otherwise. It also holds a low-power flag, plus a wake enable that lets an enabled pin event clear the low-power flag and raise a one-cycle wake request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: An edge in either direction on pin k sets status bit k at the clock edge that samples it. Bits of pins without an edge keep their value.
- R2: A read of address 0 places the status on `rdData` after the clock edge and clears the status at that same edge. An edge sampled at that edge survives into the cleared status.
- R3: After reset, the registers hold these values:
  - status = 0
  - enable (address 1) = 0
  - configuration (address 2) = 0
  - `intPin` = 1 (inactive at polarity 0)
  - `wakeReq` = 0
- R4: A pin whose enable bit is 0 still sets its status bit but never activates the interrupt.
- R5: In level style (configuration bit 0 = 0), the interrupt is active from the cycle after an enabled status bit sets until the cycle after the status read.
- R6: In pulse style (configuration bit 0 = 1), a pending enabled status starts a pulse one cycle after it sets.
  - Each pulse is active for PULSE_CYC cycles, followed by GAP_CYC inactive cycles, and the train repeats while anything is pending.
  - After a status read, the pulse in progress, or one that starts at that edge, completes, and no further pulse follows.
- R7: A further edge on a pin whose status is still unread produces no extra interrupt activity: the level stays active and the pulse cadence is unchanged.
- R8: Configuration bit 1 selects polarity. With bit 1 = 0 the active level of `intPin` is 0; with bit 1 = 1 it is 1. The inactive level is the opposite in both styles.
- R9: Wake-up behaviour depends on configuration bits 2 and 3:
  - When bit 2 (wake enable) and bit 3 (low power) are both 1, an edge on an enabled pin clears bit 3 and pulses `wakeReq` for one cycle.
  - An edge on a disabled pin, or any edge while bit 2 is 0, leaves bit 3 set and `wakeReq` at 0.
- R10: Register map: address 0 is the status (writes ignored), address 1 is the enable, address 2 is the configuration in bits 3:0, and address 3 returns the current pin levels.
- R11: Pins that are already high when reset is released do not set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NPINS | Synchronized pin levels |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regWdata | input | NPINS | Write data |
| regRd | input | 1 | Read strobe (a read of address 0 clears status) |
| rdData | output | NPINS | Read data, valid the cycle after the strobe |
| intPin | output | 1 | Interrupt pin level (pad pulls low when 0) |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
The hardest situation to reach is a pulse train whose status is read at the exact edge where the gap expires. At that edge one more pulse must start, even though the status is cleared in the same cycle. The bench reaches it by counting cycles from the first edge in a small configuration (3-cycle pulses, 5-cycle gaps) and issuing the read on the last gap cycle. An extra edge is injected mid-gap to show that the cadence does not move. A second corner is an edge on another pin in the same cycle as a status read; the bench drives both together and checks that the new bit survives into the next read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_CONFIG = 2'd2;
  localparam logic [1:0] ADDR_PINS   = 2'd3;

  localparam int CFG_W     = 4;
  localparam int CFG_PULSE = 0;
  localparam int CFG_POL   = 1;
  localparam int CFG_WAKE  = 2;
  localparam int CFG_LOWP  = 3;

  typedef struct packed {
    logic       wrEnable;
    logic       wrConfig;
    logic       rdStatus;
    logic       rdStrobe;
    logic [1:0] rdSel;
  } regStb_t;

  typedef enum logic [1:0] {
    IRQ_IDLE  = 2'd0,
    IRQ_PULSE = 2'd1,
    IRQ_GAP   = 2'd2
  } irqState_t;

endpackage

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  regStb_t          stb,
  input  logic [NPINS-1:0] regWdata,
  output logic [NPINS-1:0] rdData,
  output logic             pending,
  output logic             pulseStyle,
  output logic             activeHigh,
  output logic             wakeReq
);

  logic             armed;
  logic [NPINS-1:0] pinPrev;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] enable;
  logic [CFG_W-1:0] cfg;
  logic [NPINS-1:0] edges;
  logic             wakeHit;

  // Edge detection stays off for the first cycle after reset, so pins that
  // are already high do not look like transitions.
  assign edges   = armed ? (pinIn ^ pinPrev) : '0;
  assign wakeHit = cfg[CFG_WAKE] && cfg[CFG_LOWP] && (|(edges & enable));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      pinPrev <= '0;
    end else begin
      armed   <= 1'b1;
      pinPrev <= pinIn;
    end
  end

  // Sticky flags: a status read clears them, and a new edge always wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (stb.rdStatus ? '0 : status) | edges;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enable <= '0;
    else if (stb.wrEnable) enable <= regWdata;
  end

  // A wake event overrides a write to the low-power bit in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      wakeReq <= 1'b0;
    end else begin
      if (stb.wrConfig) cfg <= regWdata[CFG_W-1:0];
      if (wakeHit)      cfg[CFG_LOWP] <= 1'b0;
      wakeReq <= wakeHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStrobe) begin
      case (stb.rdSel)
        ADDR_STATUS: rdData <= status;
        ADDR_ENABLE: rdData <= enable;
        ADDR_CONFIG: rdData <= NPINS'(cfg);
        default:     rdData <= pinIn;
      endcase
    end
  end

  assign pending    = |(status & enable);
  assign pulseStyle = cfg[CFG_PULSE];
  assign activeHigh = cfg[CFG_POL];

  // R1: status bits are sticky while not read
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStatus |=> ((status & $past(status)) == $past(status)));

  // R1: every sampled edge lands in status
  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (edges != '0) |=> ((status & $past(edges)) == $past(edges)));

  // R2: a status read leaves only same-cycle edges
  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStatus |=> (status == $past(edges)));

  // R9: an enabled event in low power with wake enabled wakes the block
  p_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |=> (wakeReq && !cfg[CFG_LOWP]));

  // R9: without wake enable the configuration only changes by a write
  p_no_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg[CFG_WAKE] && !stb.wrConfig) |=> $stable(cfg));

endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_irq_pkg::*;
#(
  parameter int PULSE_CYC = 12,
  parameter int GAP_CYC   = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       pending,
  input  logic       pulseStyle,
  input  logic       activeHigh,
  output regStb_t    stb,
  output logic       intPin
);

  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GAP_LOAD   = CW'(GAP_CYC - 1);

  irqState_t     state;
  logic [CW-1:0] cnt;
  logic          intActive;

  always_comb begin
    stb.wrEnable = regWr && (regAddr == ADDR_ENABLE);
    stb.wrConfig = regWr && (regAddr == ADDR_CONFIG);
    stb.rdStatus = regRd && (regAddr == ADDR_STATUS);
    stb.rdStrobe = regRd;
    stb.rdSel    = regAddr;
  end

  // A pulse always completes. A new one starts from idle, or at the end of a
  // gap, while anything enabled is still pending.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IRQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        IRQ_IDLE: begin
          if (pulseStyle && pending) begin
            state <= IRQ_PULSE;
            cnt   <= PULSE_LOAD;
          end
        end
        IRQ_PULSE: begin
          if (cnt == '0) begin
            state <= IRQ_GAP;
            cnt   <= GAP_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        IRQ_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (pulseStyle && pending) begin
            state <= IRQ_PULSE;
            cnt   <= PULSE_LOAD;
          end else begin
            state <= IRQ_IDLE;
          end
        end
        default: begin
          state <= IRQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign intActive = pulseStyle ? (state == IRQ_PULSE) : pending;
  assign intPin    = activeHigh ? intActive : !intActive;

  // R6: a pulse is never cut short
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == IRQ_PULSE && cnt != '0) |=> (state == IRQ_PULSE));

  // R7: no new pulse inside a gap, whatever the pins do
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == IRQ_GAP && cnt != '0) |=> (state == IRQ_GAP));

  // R4: nothing pending from idle means no pulse
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == IRQ_IDLE && !pending) |=> (state != IRQ_PULSE));

  // R6: a pulse follows either idle or a finished gap
  p_pulse_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == IRQ_PULSE) |-> ($past(state) == IRQ_IDLE || $past(cnt) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int PULSE_CYC = 12,
  parameter int GAP_CYC   = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic [NPINS-1:0] regWdata,
  input  logic             regRd,
  output logic [NPINS-1:0] rdData,
  output logic             intPin,
  output logic             wakeReq
);

  regStb_t stb;
  logic    pending;
  logic    pulseStyle;
  logic    activeHigh;

  gpio_irq_ctl #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWr      (regWr),
    .regRd      (regRd),
    .pending    (pending),
    .pulseStyle (pulseStyle),
    .activeHigh (activeHigh),
    .stb        (stb),
    .intPin     (intPin)
  );

  gpio_irq_dp #(
    .NPINS (NPINS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .stb        (stb),
    .regWdata   (regWdata),
    .rdData     (rdData),
    .pending    (pending),
    .pulseStyle (pulseStyle),
    .activeHigh (activeHigh),
    .wakeReq    (wakeReq)
  );

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

  localparam int N  = 8;
  localparam int PW = 3;
  localparam int GW = 5;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] pinIn;
  logic [1:0]   regAddr;
  logic         regWr;
  logic [N-1:0] regWdata;
  logic         regRd;
  logic [N-1:0] rdData;
  logic         intPin;
  logic         wakeReq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .PULSE_CYC(PW), .GAP_CYC(GW)) u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRd(regRd), .rdData(rdData), .intPin(intPin),
    .wakeReq(wakeReq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    tick();
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    regAddr = a; regRd = 1'b1;
    tick();
    regRd = 1'b0;
    chk(req, 32'(rdData), 32'(exp));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; pinIn = 8'hA5; regAddr = '0; regWr = 1'b0; regRd = 1'b0; regWdata = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick(); tick();

    // R3 reset state, R11 pins high at release give no status
    chk("R3 intPin", 32'(intPin), 32'd1);
    chk("R3 wakeReq", 32'(wakeReq), 32'd0);
    rdChk("R11 status after reset", 2'd0, 8'h00);
    rdChk("R3 enable", 2'd1, 8'h00);
    rdChk("R3 config", 2'd2, 8'h00);

    // R10 map: writes to status ignored, address 3 reads pins
    wr(2'd0, 8'hFF);
    rdChk("R10 status write ignored", 2'd0, 8'h00);
    rdChk("R10 pin readback", 2'd3, 8'hA5);

    // R1 sweep every pin both directions; R4 disabled pins never interrupt
    for (int b = 0; b < N; b++) begin
      for (int d = 0; d < 2; d++) begin
        pinIn = pinIn ^ N'(1 << b);
        tick();
        chk("R4 disabled no int", 32'(intPin), 32'd1);
        rdChk("R1 edge sets bit", 2'd0, N'(1 << b));
      end
    end

    // R5 level style, R8 polarity, R7 further edges change nothing
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd2, N'(pol << 1));
      for (int b = 0; b < N; b++) begin
        int o;
        o = (b + 1) % N;
        wr(2'd1, N'(1 << b));
        chk("R8 inactive level", 32'(intPin), 32'(pol == 0));
        pinIn = pinIn ^ N'(1 << b);
        tick();
        chk("R5 level active", 32'(intPin), 32'(pol == 1));
        tick();
        pinIn = pinIn ^ N'(1 << b) ^ N'(1 << o);
        tick();
        chk("R7 level unchanged", 32'(intPin), 32'(pol == 1));
        rdChk("R5 status read", 2'd0, N'((1 << b) | (1 << o)));
        chk("R5 released after read", 32'(intPin), 32'(pol == 0));
      end
    end

    // R2 edge in the same cycle as the status read survives
    wr(2'd1, 8'h00);
    pinIn = pinIn ^ 8'h02;
    tick();
    pinIn = pinIn ^ 8'h04;
    rdChk("R2 read value", 2'd0, 8'h02);
    rdChk("R2 same-cycle edge kept", 2'd0, 8'h04);

    // R6 pulse cadence, R7 mid-gap edge, R8 polarity in pulse style
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd1, 8'h01);
      wr(2'd2, N'(1 | (pol << 1)));
      pinIn = pinIn ^ 8'h01;
      tick();
      chk("R8 pulse idle level", 32'(intPin), 32'(pol == 0));
      for (int n = 1; n <= 16; n++) begin
        logic act;
        if (n == 5) pinIn = pinIn ^ 8'h01;
        tick();
        act = ((n - 1) % (PW + GW)) < PW;
        chk("R6 R7 pulse train", 32'(intPin), 32'(act ? (pol == 1) : (pol == 0)));
      end
      rdChk("R6 status in pulse", 2'd0, 8'h01);
      chk("R6 last pulse starts", 32'(intPin), 32'(pol == 1));
      for (int m = 18; m <= 40; m++) begin
        tick();
        chk("R6 train stops", 32'(intPin), 32'((m <= 19) ? (pol == 1) : (pol == 0)));
      end
    end

    // R9 wake-up
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h0C);
    pinIn = pinIn ^ 8'h02;
    tick();
    chk("R9 disabled pin no wake", 32'(wakeReq), 32'd0);
    rdChk("R9 low power kept", 2'd2, 8'h0C);
    pinIn = pinIn ^ 8'h01;
    tick();
    chk("R9 wake pulse", 32'(wakeReq), 32'd1);
    tick();
    chk("R9 wake one cycle", 32'(wakeReq), 32'd0);
    rdChk("R9 low power cleared", 2'd2, 8'h04);
    rdChk("R9 status", 2'd0, 8'h03);
    wr(2'd2, 8'h08);
    pinIn = pinIn ^ 8'h01;
    tick();
    chk("R9 no wake enable", 32'(wakeReq), 32'd0);
    rdChk("R9 low power held", 2'd2, 8'h08);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule